// File: doc/BRIEF.md
# Atomic Set/Clear Control Register Bank

This block holds a small bank of 32-bit global control registers that several bus masters share. Each register can be reached through three address windows. The plain window reads the register and writes it as a whole word. The set window ORs the write data into the register, and the clear window removes the bits that are 1 in the write data. A master can therefore change its own bits of a shared register in a single write. No read-modify-write sequence is needed, and no hardware lock is needed to guard one.

The window is chosen by address bits [13:12] and the register by bits [11:2]. Byte strobes limit every kind of write to the enabled byte lanes. Each access gets a registered response one cycle after it is presented: a ready pulse for a good access, or an error pulse for an unmapped one. Every register value drives a flat output vector for the rest of the chip.

Top module: `gctl_alias_bank`

## Requirements
- R1: After synchronous active-high reset every register is zero, `reg_out` is zero, and `bus_ready`, `bus_err` and `bus_rdata` are zero.
- R2: Window code 00 (offset 0x0000) is the plain view. A write replaces the enabled bytes of the addressed register with the write data. A read returns the current value in `bus_rdata`, with `bus_ready` high in the cycle after the request. An idle cycle produces no response.
- R3: Window code 01 (offset 0x1000) ORs the enabled bytes of the write data into the register. No bit that was 1 ever becomes 0.
- R4: Window code 10 (offset 0x2000) clears every enabled bit that is 1 in the write data. No bit that was 0 ever becomes 1.
- R5: A write of all zeros to the set or clear window leaves the register unchanged.
- R6: Byte strobe k enables data bits [8k+7:8k] (little-endian lanes) in all three windows. Disabled lanes keep their old value.
- R7: A read through the set or clear window returns the same value as a read through the plain window.
- R8: An access with window code 11, or with a register index (bits [11:2]) of `NUM_REGS` or more, gives `bus_err` high, `bus_ready` low and `bus_rdata` zero in the next cycle, and changes no register.
- R9: Writes apply one at a time, in arrival order. A set followed by a clear shows the intermediate value on `reg_out` for one cycle, and then the final value.
- R10: Register i appears at `reg_out[32*i+31:32*i]`. A write shows there in the cycle after the edge that accepts it. Without a write, the registers do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 14 | Byte offset: [13:12] window, [11:2] register index |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte lane enables for the write |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Access completed without error (one cycle after request) |
| bus_err | output | 1 | Access rejected as unmapped (one cycle after request) |
| reg_out | output | 32*NUM_REGS | All register values, register i at bits [32i+31:32i] |

## Verification
If the register state goes wrong, the fault shows on `reg_out` in the cycle right after the edge that accepted the write. A corrupt bit is therefore seen one cycle after the write that caused it. It is also seen when any window reads that register back, because `bus_rdata` arrives one cycle after the read. Bad window decoding shows in three ways: bits move in the wrong direction, a neighbouring register changes, or a response carries `bus_err` where `bus_ready` was due, or the other way round. The set-then-clear sequence checks ordering, because the intermediate value can be seen on `reg_out` for exactly one cycle.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'b00,
    WIN_SET   = 2'b01,
    WIN_CLR   = 2'b10,
    WIN_BAD   = 2'b11
  } win_e;

  // Expand per-lane enables into a per-bit mask (lane k -> bits 8k+7:8k)
  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] strb);
    logic [WORD_W-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{strb[k]}};
    return m;
  endfunction

  // Value a register takes after one accepted write through a window
  function automatic logic [WORD_W-1:0] apply_write(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] data,
    input logic [WORD_W-1:0] mask,
    input win_e              win
  );
    logic [WORD_W-1:0] sel;
    sel = data & mask;
    case (win)
      WIN_PLAIN: return (cur & ~mask) | sel;
      WIN_SET:   return cur | sel;
      WIN_CLR:   return cur & ~sel;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/gctl_decode.sv
module gctl_decode
  import gctl_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 14,
  localparam int WIN_LSB = ADDR_W - 2,
  localparam int IDXF_W  = WIN_LSB - 2,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx,
  output logic              ok
);
  localparam logic [IDXF_W-1:0] REG_LIMIT = IDXF_W'(NUM_REGS);

  logic [IDXF_W-1:0] idx_full;

  always_comb begin
    win      = win_e'(addr[ADDR_W-1:WIN_LSB]);
    idx_full = addr[WIN_LSB-1:2];
    idx      = idx_full[IDX_W-1:0];
    ok       = (win != WIN_BAD) && (idx_full < REG_LIMIT);
  end
endmodule

// File: rtl/gctl_reg_cell.sv
module gctl_reg_cell
  import gctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  win_e              win,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= apply_write(q, wdata, mask, win);
  end
endmodule

// File: rtl/gctl_resp.sv
module gctl_resp
  import gctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              wr,
  input  logic              ok,
  input  logic [WORD_W-1:0] rd_word,
  output logic              ready,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);
  logic req;
  assign req = rd | wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req & ok;
      err   <= req & ~ok;
      rdata <= (rd & ok) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/gctl_alias_bank.sv
module gctl_alias_bank
  import gctl_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ADDR_W   = 14,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [WORD_W-1:0]          bus_wdata,
  input  logic [LANES-1:0]           bus_strb,
  input  logic                       bus_rd,
  output logic [WORD_W-1:0]          bus_rdata,
  output logic                       bus_ready,
  output logic                       bus_err,
  output logic [NUM_REGS*WORD_W-1:0] reg_out
);
  // Named internal events (also observed by the bound checker)
  win_e                             acc_win;
  logic [IDX_W-1:0]                 acc_idx;
  logic                             acc_ok;
  logic                             wr_hit;
  logic                             rd_hit;
  logic [WORD_W-1:0]                wr_mask;
  logic [WORD_W-1:0]                rd_word;
  logic [NUM_REGS-1:0][WORD_W-1:0]  regs;

  gctl_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .win  (acc_win),
    .idx  (acc_idx),
    .ok   (acc_ok)
  );

  assign wr_hit  = bus_wr & acc_ok;
  assign rd_hit  = bus_rd & acc_ok;
  assign wr_mask = lane_mask(bus_strb);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    gctl_reg_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_hit && (acc_idx == IDX_W'(i))),
      .win   (acc_win),
      .wdata (bus_wdata),
      .mask  (wr_mask),
      .q     (regs[i])
    );
  end

  assign rd_word = rd_hit ? regs[acc_idx] : '0;

  gctl_resp u_resp (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .ok      (acc_ok),
    .rd_word (rd_word),
    .ready   (bus_ready),
    .err     (bus_err),
    .rdata   (bus_rdata)
  );

  assign reg_out = regs;
endmodule

// File: rtl/gctl_alias_bank_chk.sv
module gctl_alias_bank_chk
  import gctl_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic                       bus_ready,
  input logic                       bus_err,
  input logic [WORD_W-1:0]          bus_rdata,
  input logic                       acc_ok,
  input win_e                       acc_win,
  input logic                       wr_hit,
  input logic [NUM_REGS*WORD_W-1:0] reg_out
);
  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && acc_win == WIN_SET) |=> ((~reg_out & $past(reg_out)) == '0)); // R3

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && acc_win == WIN_CLR) |=> ((reg_out & ~$past(reg_out)) == '0)); // R4

  AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !acc_ok) |=> $stable(reg_out)); // R8

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (!bus_ready && bus_rdata == '0)); // R8

  AST_REQ_GETS_RESP: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |=> (bus_ready || bus_err)); // R2

  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd || bus_wr) |=> !(bus_ready || bus_err)); // R2

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(reg_out)); // R10
endmodule

bind gctl_alias_bank gctl_alias_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .bus_rdata (bus_rdata),
  .acc_ok    (acc_ok),
  .acc_win   (acc_win),
  .wr_hit    (wr_hit),
  .reg_out   (reg_out)
);

// File: tb/test_gctl_alias_bank.sv
module test_gctl_alias_bank;
  localparam int NR = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [13:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [3:0]    bus_strb = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_ready;
  logic          bus_err;
  logic [NR*32-1:0] reg_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mdl [NR];

  gctl_alias_bank i_gctl_alias_bank (
    .clk, .rst, .bus_addr, .bus_wr, .bus_wdata, .bus_strb, .bus_rd,
    .bus_rdata, .bus_ready, .bus_err, .reg_out
  );

  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench model: bit by bit, lane k covers bits 8k..8k+7
  task automatic model_write(input int r, input logic [1:0] w,
                             input logic [31:0] d, input logic [3:0] s);
    for (int b = 0; b < 32; b++) begin
      if (s[b/8]) begin
        if (w == 2'b00) mdl[r][b] = d[b];
        else if (w == 2'b01 && d[b]) mdl[r][b] = 1'b1;
        else if (w == 2'b10 && d[b]) mdl[r][b] = 1'b0;
      end
    end
  endtask

  // One bus access: drive at negedge, sample response at the next negedge
  task automatic access(input logic wr, input logic rd, input logic [13:0] a,
                        input logic [31:0] d, input logic [3:0] s,
                        output logic rdy, output logic er, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; bus_strb = s;
    @(negedge clk);
    rdy = bus_ready; er = bus_err; q = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; bus_strb = '0; bus_addr = '0;
  endtask

  task automatic wr_ok(input string req, input int r, input logic [1:0] w,
                       input logic [31:0] d, input logic [3:0] s);
    logic rdy, er; logic [31:0] q;
    access(1'b1, 1'b0, {w, 10'(r), 2'b00}, d, s, rdy, er, q);
    model_write(r, w, d, s);
    chk(req, "write ready", {31'd0, rdy}, 32'd1);
    chk(req, $sformatf("reg_out[%0d] after write", r), reg_out[r*32 +: 32], mdl[r]);
  endtask

  task automatic rd_ok(input string req, input int r, input logic [1:0] w);
    logic rdy, er; logic [31:0] q;
    access(1'b0, 1'b1, {w, 10'(r), 2'b00}, '0, '0, rdy, er, q);
    chk(req, "read ready", {31'd0, rdy}, 32'd1);
    chk(req, $sformatf("read data reg %0d win %0d", r, w), q, mdl[r]);
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < NR; r++)
      chk(req, $sformatf("reg_out[%0d]", r), reg_out[r*32 +: 32], mdl[r]);
  endtask

  task automatic t_reset;
    for (int r = 0; r < NR; r++) mdl[r] = '0;
    check_all("R1");
    chk("R1", "ready/err after reset", {30'd0, bus_ready, bus_err}, 32'd0);
    chk("R1", "rdata after reset", bus_rdata, 32'd0);
    @(negedge clk);
    chk("R2", "idle gives no response", {30'd0, bus_ready, bus_err}, 32'd0);
  endtask

  task automatic t_plain;
    wr_ok("R2", 0, 2'b00, 32'hDEAD_BEEF, 4'hF);
    wr_ok("R2", 15, 2'b00, 32'h1234_5678, 4'hF);
    wr_ok("R2", 0, 2'b00, 32'h0F0F_0000, 4'hF);
    rd_ok("R2", 0, 2'b00);
    rd_ok("R2", 15, 2'b00);
    check_all("R10");
  endtask

  task automatic t_set;
    wr_ok("R3", 3, 2'b00, 32'h0000_00F0, 4'hF);
    wr_ok("R3", 3, 2'b01, 32'h8000_0011, 4'hF);
    chk("R3", "set result", reg_out[3*32 +: 32], 32'h8000_00F1);
    rd_ok("R3", 3, 2'b00);
  endtask

  task automatic t_clear;
    wr_ok("R4", 4, 2'b00, 32'hFFFF_FFFF, 4'hF);
    wr_ok("R4", 4, 2'b10, 32'h0000_FF01, 4'hF);
    chk("R4", "clear result", reg_out[4*32 +: 32], 32'hFFFF_00FE);
    rd_ok("R4", 4, 2'b00);
    check_all("R10");
  endtask

  task automatic t_zero;
    wr_ok("R5", 6, 2'b00, 32'hA5A5_5A5A, 4'hF);
    wr_ok("R5", 6, 2'b01, 32'h0, 4'hF);
    chk("R5", "zero set keeps", reg_out[6*32 +: 32], 32'hA5A5_5A5A);
    wr_ok("R5", 6, 2'b10, 32'h0, 4'hF);
    chk("R5", "zero clear keeps", reg_out[6*32 +: 32], 32'hA5A5_5A5A);
  endtask

  task automatic t_strobes;
    wr_ok("R6", 7, 2'b00, 32'h1122_3344, 4'hF);
    wr_ok("R6", 7, 2'b00, 32'hAABB_CCDD, 4'b0101);
    chk("R6", "plain lanes 0,2", reg_out[7*32 +: 32], 32'h11BB_33DD);
    wr_ok("R6", 7, 2'b01, 32'hFFFF_FFFF, 4'b1000);
    chk("R6", "set lane 3", reg_out[7*32 +: 32], 32'hFFBB_33DD);
    wr_ok("R6", 7, 2'b10, 32'hFFFF_FFFF, 4'b0010);
    chk("R6", "clear lane 1", reg_out[7*32 +: 32], 32'hFFBB_00DD);
    wr_ok("R6", 7, 2'b00, 32'h0, 4'b0000);
    chk("R6", "no lanes", reg_out[7*32 +: 32], 32'hFFBB_00DD);
  endtask

  task automatic t_alias_read;
    wr_ok("R7", 9, 2'b00, 32'hCAFE_F00D, 4'hF);
    rd_ok("R7", 9, 2'b01);
    rd_ok("R7", 9, 2'b10);
  endtask

  task automatic t_errors;
    logic rdy, er; logic [31:0] q;
    wr_ok("R8", 2, 2'b00, 32'h5555_AAAA, 4'hF);
    access(1'b1, 1'b0, {2'b11, 10'd2, 2'b00}, 32'hFFFF_FFFF, 4'hF, rdy, er, q);
    chk("R8", "win 11 write err/ready", {30'd0, er, rdy}, 32'd2);
    check_all("R8");
    access(1'b0, 1'b1, {2'b11, 10'd2, 2'b00}, '0, '0, rdy, er, q);
    chk("R8", "win 11 read err/ready", {30'd0, er, rdy}, 32'd2);
    chk("R8", "win 11 read data", q, 32'd0);
    access(1'b1, 1'b0, {2'b01, 10'd18, 2'b00}, 32'hFFFF_FFFF, 4'hF, rdy, er, q);
    chk("R8", "index 18 write err", {30'd0, er, rdy}, 32'd2);
    check_all("R8");
    access(1'b0, 1'b1, {2'b00, 10'd16, 2'b00}, '0, '0, rdy, er, q);
    chk("R8", "index 16 read err", {30'd0, er, rdy}, 32'd2);
    chk("R8", "index 16 read data", q, 32'd0);
  endtask

  task automatic t_sequence;
    wr_ok("R9", 5, 2'b00, 32'h0000_000F, 4'hF);
    wr_ok("R9", 5, 2'b01, 32'h0000_00F0, 4'hF);
    chk("R9", "intermediate after set", reg_out[5*32 +: 32], 32'h0000_00FF);
    wr_ok("R9", 5, 2'b10, 32'h0000_000F, 4'hF);
    chk("R9", "final after clear", reg_out[5*32 +: 32], 32'h0000_00F0);
    check_all("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_set();
    t_clear();
    t_zero();
    t_strobes();
    t_alias_read();
    t_errors();
    t_sequence();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule